// File: doc/BRIEF.md
# Processor Supervisor Reset Generator

This block produces the single active-high reset that holds a processor while its environment is unsafe. It watches a vector of digital supply-good flags from external voltage comparators, together with a bouncing, active-low manual reset button. While any rail flag is low, or while a debounced button press is in progress, the processor reset stays asserted. A separate power-fail output shows that the reset comes from a supply fault.

When every cause has cleared, reset is released at once, or after a fixed post-release hold interval if the stretch-enable input is 1. When a manual press is accepted, the block sends a one-cycle clear pulse to companion timers, such as a watchdog. All intervals are computed from the `CLK_HZ` parameter, so a bench can shrink the millisecond intervals to a few hundred cycles.

The controller is a four-state machine:
- `ST_POWERON` is entered on the synchronous power-on reset.
- `ST_HOLD` is occupied while a cause is active.
- `ST_STRETCH` runs the post-release hold counter.
- `ST_RUN` means reset is released.

The transitions are:
- POWERON goes to HOLD if a cause is present. Otherwise it goes to STRETCH when stretch is enabled, or to RUN when it is not.
- HOLD goes to STRETCH or RUN once the causes clear, with the same choice as above.
- STRETCH goes to HOLD when a cause appears, and has priority over expiry. Otherwise it goes to RUN when the count expires.
- RUN goes to HOLD when a cause appears.

Top module: `proc_reset_supervisor`

## Requirements
- R1: A low level on any bit of `supply_ok` drives `cpu_reset` to 1 on the third rising edge after the change, and `cpu_reset` stays 1 while that flag stays low.
- R2: With `stretch_en` = 0, `cpu_reset` returns to 0 on the third rising edge after the last active cause clears.
- R3: `power_fail` is 1 exactly when at least one synchronised supply flag is low, with a latency of two clock edges.
- R4: `btn_n` is active low and passes through a two-flop synchroniser. A level change is accepted only after `DB_CYC` consecutive cycles at the new level, so a press that lasts `DB_CYC`-1 cycles causes neither reset nor a clear pulse.
- R5: An accepted press gives exactly one single-cycle `timers_clear` pulse, seen `DB_CYC`+2 edges after the press. It also asserts `cpu_reset` one edge after the pulse.
- R6: With `stretch_en` = 1, `cpu_reset` returns to 0 on edge 3+`ST_CYC` after the last cause clears.
- R7: A cause that appears during the stretch returns the machine to HOLD and restarts the full stretch once the cause clears. This also holds when the cause arrives in the final stretch cycle.
- R8: While `rst_sync` is 1, `cpu_reset` is 1 and `timers_clear` is 0. After `rst_sync` falls with no cause present and stretch off, `cpu_reset` falls on the next edge.
- R9: `DB_CYC` = `CLK_HZ`*`DEBOUNCE_MS`/1000 and `ST_CYC` = `CLK_HZ`*`STRETCH_MS`/1000. The defaults are 20 ms and 200 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_sync | input | 1 | Synchronous power-on reset, active high |
| supply_ok | input | N_RAILS | Supply-good flags from the rail comparators, 1 = in tolerance |
| btn_n | input | 1 | Raw manual reset button, active low, may bounce |
| stretch_en | input | 1 | 1 = hold reset for the stretch interval after release |
| cpu_reset | output | 1 | Processor reset, active high |
| power_fail | output | 1 | High while any supply flag is low |
| timers_clear | output | 1 | One-cycle pulse clearing companion timers on an accepted press |

## Verification
Two functions can decide the same cycle: expiry of the stretch count and arrival of a new cause. The bench restores a rail with stretch on, then drops another rail at exactly the moment its synchronised fault reaches the state register in the terminal stretch cycle. It then expects `cpu_reset` never to fall, and expects a full new stretch after the second rail recovers. Separately, a button press one cycle shorter than the debounce window is judged against the press that is one cycle longer, which must produce the clear pulse and the reset on computed edges.

// File: rtl/prs_pkg.sv
package prs_pkg;
    typedef enum logic [1:0] {
        ST_POWERON = 2'd0,
        ST_HOLD    = 2'd1,
        ST_STRETCH = 2'd2,
        ST_RUN     = 2'd3
    } prs_state_t;
endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/prs_debounce.sv
module prs_debounce #(
    parameter int unsigned DB_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_n,
    output logic pressed,
    output logic press_pulse
);
    localparam int unsigned CW = (DB_CYC > 1) ? $clog2(DB_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DB_CYC - 1);

    logic          acc_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q       <= 1'b1;
            cnt_q       <= '0;
            press_pulse <= 1'b0;
        end else begin
            press_pulse <= 1'b0;
            if (lvl_n != acc_q) begin
                if (cnt_q == LAST) begin
                    acc_q       <= lvl_n;
                    cnt_q       <= '0;
                    press_pulse <= ~lvl_n;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign pressed = ~acc_q;
endmodule

// File: rtl/prs_fsm.sv
module prs_fsm
    import prs_pkg::*;
#(
    parameter int unsigned ST_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic cause,
    input  logic stretch_en,
    output logic cpu_reset
);
    localparam int unsigned CW = (ST_CYC > 1) ? $clog2(ST_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(ST_CYC - 1);

    prs_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_POWERON;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_POWERON, ST_HOLD: begin
                if (cause)           state_d = ST_HOLD;
                else if (stretch_en) state_d = ST_STRETCH;
                else                 state_d = ST_RUN;
            end
            ST_STRETCH: begin
                if (cause) begin
                    state_d = ST_HOLD;
                end else if (cnt_q == LAST) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (cause) state_d = ST_HOLD;
            end
            default: state_d = ST_POWERON;
        endcase
    end

    always_comb begin
        cpu_reset = (state_q != ST_RUN);
    end
endmodule

// File: rtl/proc_reset_supervisor.sv
module proc_reset_supervisor #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned N_RAILS     = 3,
    parameter int unsigned DEBOUNCE_MS = 20,
    parameter int unsigned STRETCH_MS  = 200
) (
    input  logic               clk,
    input  logic               rst_sync,
    input  logic [N_RAILS-1:0] supply_ok,
    input  logic               btn_n,
    input  logic               stretch_en,
    output logic               cpu_reset,
    output logic               power_fail,
    output logic               timers_clear
);
    localparam int unsigned DB_RAW = (CLK_HZ / 1000) * DEBOUNCE_MS;
    localparam int unsigned ST_RAW = (CLK_HZ / 1000) * STRETCH_MS;
    localparam int unsigned DB_CYC = (DB_RAW > 0) ? DB_RAW : 1;
    localparam int unsigned ST_CYC = (ST_RAW > 0) ? ST_RAW : 1;

    logic [N_RAILS-1:0] ok_s;
    logic               btn_s;
    logic               pressed;
    logic               press_pulse;
    logic               fault;

    prs_sync #(.W(N_RAILS), .RST_VAL({N_RAILS{1'b1}})) u_rail_sync (
        .clk (clk),
        .rst (rst_sync),
        .d   (supply_ok),
        .q   (ok_s)
    );

    prs_sync #(.W(1), .RST_VAL(1'b1)) u_btn_sync (
        .clk (clk),
        .rst (rst_sync),
        .d   (btn_n),
        .q   (btn_s)
    );

    prs_debounce #(.DB_CYC(DB_CYC)) u_debounce (
        .clk         (clk),
        .rst         (rst_sync),
        .lvl_n       (btn_s),
        .pressed     (pressed),
        .press_pulse (press_pulse)
    );

    assign fault = ~(&ok_s);

    prs_fsm #(.ST_CYC(ST_CYC)) u_fsm (
        .clk        (clk),
        .rst        (rst_sync),
        .cause      (fault | pressed),
        .stretch_en (stretch_en),
        .cpu_reset  (cpu_reset)
    );

    assign power_fail   = fault;
    assign timers_clear = press_pulse;
endmodule

// File: rtl/prs_checker.sv
module prs_checker (
    input logic clk,
    input logic rst_sync,
    input logic cpu_reset,
    input logic power_fail,
    input logic timers_clear
);
    // R1: a fault seen on power_fail forces reset on the next edge
    assert_fault_holds_reset_R1: assert property (@(posedge clk) disable iff (rst_sync)
        power_fail |=> cpu_reset);

    // R2: release only happens with no supply fault present
    assert_release_clean_R2: assert property (@(posedge clk) disable iff (rst_sync)
        $fell(cpu_reset) |-> !power_fail);

    // R5: the clear pulse lasts one cycle
    assert_clear_single_R5: assert property (@(posedge clk) disable iff (rst_sync)
        timers_clear |=> !timers_clear);

    // R5: the clear pulse is followed by reset
    assert_clear_then_reset_R5: assert property (@(posedge clk) disable iff (rst_sync)
        timers_clear |=> cpu_reset);

    // R8: power-on reset holds the processor reset
    assert_por_reset_R8: assert property (@(posedge clk)
        rst_sync |=> cpu_reset);

    // R8: no clear pulse during power-on reset
    always @(negedge clk) begin
        if (rst_sync) begin
            assert_por_noclear_R8: assert (!timers_clear);
        end
    end
endmodule

bind proc_reset_supervisor prs_checker u_prs_checker (
    .clk          (clk),
    .rst_sync     (rst_sync),
    .cpu_reset    (cpu_reset),
    .power_fail   (power_fail),
    .timers_clear (timers_clear)
);

// File: tb/proc_reset_supervisor_tb.sv
`timescale 1ns/1ps
module proc_reset_supervisor_tb_top;
    localparam int CLK_HZ = 10_000;
    localparam int NR     = 3;
    localparam int DB     = CLK_HZ * 20 / 1000;   // R9
    localparam int ST     = CLK_HZ * 200 / 1000;  // R9

    logic          clk = 1'b0;
    logic          rst_sync;
    logic [NR-1:0] supply_ok;
    logic          btn_n;
    logic          stretch_en;
    logic          cpu_reset;
    logic          power_fail;
    logic          timers_clear;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    proc_reset_supervisor #(
        .CLK_HZ(CLK_HZ), .N_RAILS(NR), .DEBOUNCE_MS(20), .STRETCH_MS(200)
    ) dut_i (
        .clk(clk), .rst_sync(rst_sync), .supply_ok(supply_ok), .btn_n(btn_n),
        .stretch_en(stretch_en), .cpu_reset(cpu_reset), .power_fail(power_fail),
        .timers_clear(timers_clear)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts negedges after the current one until cpu_reset is low.
    task automatic time_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cpu_reset && n < ST + 50);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int clr_n;
        int rst_n;
        int clr_cnt;
        int hi;
        rst_sync   = 1'b1;
        supply_ok  = '1;
        btn_n      = 1'b1;
        stretch_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 reset asserted in por", cpu_reset, 1);
        chk("R8 no clear in por", timers_clear, 0);
        rst_sync = 1'b0;
        @(negedge clk);
        chk("R8 release after por", cpu_reset, 0);

        // R1 R2 R3: every supply pattern, stretch off
        for (int p = 0; p < (1 << NR); p++) begin
            supply_ok = NR'(p);
            @(negedge clk);
            @(negedge clk);
            chk("R3 power_fail pattern", power_fail, (p != (1 << NR) - 1) ? 1 : 0);
            @(negedge clk);
            chk("R1 reset pattern", cpu_reset, (p != (1 << NR) - 1) ? 1 : 0);
            if (p != (1 << NR) - 1) begin
                repeat (4) @(negedge clk);
                chk("R1 reset held", cpu_reset, 1);
                supply_ok = '1;
                time_release(n);
                chk("R2 release latency", n, 3);
                chk("R3 power_fail clear", power_fail, 0);
            end
        end

        // R6: stretch on, each rail
        stretch_en = 1'b1;
        for (int r = 0; r < NR; r++) begin
            supply_ok    = '1;
            supply_ok[r] = 1'b0;
            repeat (5) @(negedge clk);
            supply_ok = '1;
            time_release(n);
            chk("R6 stretch release", n, 3 + ST);
        end

        // R7: new cause mid-stretch restarts the stretch
        supply_ok[0] = 1'b0;
        repeat (5) @(negedge clk);
        supply_ok = '1;
        repeat (ST / 2) @(negedge clk);
        chk("R7 mid stretch held", cpu_reset, 1);
        supply_ok[1] = 1'b0;
        repeat (10) @(negedge clk);
        supply_ok = '1;
        time_release(n);
        chk("R7 restarted stretch", n, 3 + ST);

        // R7: cause reaching the FSM in the terminal stretch cycle wins
        supply_ok[2] = 1'b0;
        repeat (5) @(negedge clk);
        supply_ok = '1;
        repeat (ST) @(negedge clk);
        supply_ok[2] = 1'b0;
        hi = 1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!cpu_reset) hi = 0;
        end
        chk("R7 collision reset kept", hi, 1);
        supply_ok = '1;
        time_release(n);
        chk("R7 collision new stretch", n, 3 + ST);

        // R4: glitch one cycle short of the debounce window
        stretch_en = 1'b0;
        btn_n = 1'b0;
        repeat (DB - 1) @(negedge clk);
        btn_n = 1'b1;
        clr_cnt = 0;
        hi = 0;
        for (int k = 0; k < DB + 10; k++) begin
            @(negedge clk);
            if (timers_clear) clr_cnt++;
            if (cpu_reset) hi = 1;
        end
        chk("R4 short press no clear", clr_cnt, 0);
        chk("R4 short press no reset", hi, 0);

        // R5: accepted press
        btn_n = 1'b0;
        clr_n = 0;
        rst_n = 0;
        clr_cnt = 0;
        for (int k = 1; k <= DB + 20; k++) begin
            @(negedge clk);
            if (timers_clear) begin
                clr_cnt++;
                if (clr_n == 0) clr_n = k;
            end
            if (cpu_reset && rst_n == 0) rst_n = k;
        end
        chk("R5 clear pulse count", clr_cnt, 1);
        chk("R5 clear pulse edge", clr_n, DB + 2);
        chk("R5 reset edge", rst_n, DB + 3);
        btn_n = 1'b1;
        time_release(n);
        chk("R4 release debounced", n, DB + 3);
        chk("R5 no clear on release", timers_clear, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule